// File: doc/BRIEF.md
# Receive destination address filter

This block sits on the receive path of an Ethernet port and decides, per frame, whether the frame is kept or thrown away. It watches a byte-serial frame stream (`in_valid`, `in_sof`, `in_data`) and looks only at the leading address bytes, which carry the destination address. It checks them against a programmable station address and a small set of mode bits. It then raises exactly one of `accept` or `drop` for a single cycle. Payload, CRC and length are of no concern to it.

The decision follows a fixed priority. Promiscuous mode accepts everything. Otherwise the all-ones address is governed by the broadcast enable. Any other address with the group bit (bit 0 of the first byte) set is governed by the group enable, with no hash filtering. All remaining addresses must match the station address exactly.

The station address and the mode bits are loaded through a synchronous byte-wide write port. The filter captures a copy of them at each start-of-frame beat, so a write affects only frames that start later.

The controller has three states:
- `ST_IDLE`: no frame has been seen since reset.
- `ST_HDR`: address bytes are being collected.
- `ST_TAIL`: the decision has been made and the rest of the frame is ignored.

The transitions are:
- Any state goes to `ST_HDR` on a start-of-frame beat.
- `ST_HDR` goes to `ST_TAIL` on the last address byte.
- Every other condition holds the current state.

Top module: `rx_dest_filter`

## Requirements
- R1: When mode bit 4 (write value mask 0x10) is set, every frame is accepted regardless of destination.
- R2: Without promiscuous mode, the destination FF:FF:FF:FF:FF:FF is accepted exactly when mode bit 2 (mask 0x04) is set, and dropped otherwise.
- R3: Without promiscuous mode, a destination that is not all ones and has bit 0 of its first byte set is accepted exactly when mode bit 3 (mask 0x08) is set, whatever its other bytes hold.
- R4: Without promiscuous mode, any other destination is accepted only when all six bytes equal the station address, with byte 0 as the first byte on the wire.
- R5: After reset, `accept` and `drop` are low, the mode bits are all clear, and the station address is 52:54:00:12:34:56.
- R6: The broadcast test takes precedence over the group test: with mode 0x08 a broadcast frame is dropped.
- R7: For each frame, exactly one of `accept`/`drop` pulses high for one cycle. The pulse comes in the cycle after the sixth destination byte is taken. Idle cycles may occur between bytes. No pulse occurs for any other beat, including bytes after the sixth.
- R8: A start-of-frame beat restarts address collection with that byte as byte 0, which cancels a partly collected address without a decision. Beats without start-of-frame outside a frame header are ignored.
- R9: A write with `cfg_wr_en` high stores `cfg_wr_data`. Addresses 0..5 set station byte 0..5, and address 6 sets the mode bits from data bits 4, 3 and 2. A write made during a frame, or in the same cycle as its start-of-frame beat, applies only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_data | input | BYTE_W | Frame byte |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW | 0..5 station byte, 6 mode bits |
| cfg_wr_data | input | BYTE_W | Configuration write data |
| accept | output | 1 | One-cycle pulse: frame is kept |
| drop | output | 1 | One-cycle pulse: frame is discarded |

## Verification
The bench builds the filter with its default parameters: 8-bit bytes, six address bytes and the station reset value 52:54:00:12:34:56. These values give it the full address width, so every path can be reached. Promiscuous, broadcast-versus-group precedence, group frames with arbitrary trailing bytes, and single-bit misses against the station can all be driven. With six address bytes there is room for an abandoned header to be cut off by a new start-of-frame beat, and for configuration writes to land at any byte position inside a header, including on the start-of-frame beat itself.

// File: rtl/adf_pkg.sv
package adf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_TAIL
    } adf_state_e;

    // Positions of the mode bits inside the configuration byte.
    localparam int MODE_BCAST_BIT   = 2;
    localparam int MODE_GROUP_BIT   = 3;
    localparam int MODE_PROMISC_BIT = 4;

    typedef struct packed {
        logic promisc;
        logic group_en;
        logic bcast_en;
    } adf_mode_t;

endpackage

// File: rtl/adf_cfg_regs.sv
module adf_cfg_regs
    import adf_pkg::*;
#(
    parameter int                          BYTE_W      = 8,
    parameter int                          ADDR_BYTES  = 6,
    parameter logic [ADDR_BYTES*BYTE_W-1:0] STATION_RST = 48'h525400123456,
    parameter int                          CFG_AW      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CFG_AW-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [ADDR_BYTES*BYTE_W-1:0] station_o,
    output adf_mode_t                    mode_o
);

    localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(ADDR_BYTES);

    // Byte i of station_o is byte i on the wire; the reset constant is
    // written most significant byte first.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_stn
        always_ff @(posedge clk) begin
            if (!rst_n)
                station_o[i*BYTE_W +: BYTE_W] <= STATION_RST[(ADDR_BYTES-1-i)*BYTE_W +: BYTE_W];
            else if (wr_en && (wr_addr == CFG_AW'(i)))
                station_o[i*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
        end else if (wr_en && (wr_addr == MODE_ADDR)) begin
            mode_o.promisc  <= wr_data[MODE_PROMISC_BIT];
            mode_o.group_en <= wr_data[MODE_GROUP_BIT];
            mode_o.bcast_en <= wr_data[MODE_BCAST_BIT];
        end
    end

endmodule

// File: rtl/adf_dest_track.sv
module adf_dest_track
    import adf_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         beat,
    input  logic                         sof,
    input  logic [BYTE_W-1:0]            data,
    input  logic                         collecting,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station_live,
    input  adf_mode_t                    mode_live,
    output logic                         last_beat,
    output logic                         cur_bcast,
    output logic                         cur_group,
    output logic                         cur_match,
    output adf_mode_t                    snap_mode
);

    localparam int IDX_W = $clog2(ADDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    logic [IDX_W-1:0]            idx_q;
    logic                        ones_q;
    logic                        match_q;
    logic                        group_q;
    logic [ADDR_BYTES*BYTE_W-1:0] snap_station;

    logic                        sof_beat;
    logic                        hdr_beat;
    logic [IDX_W-1:0]            cur_idx;
    logic [ADDR_BYTES*BYTE_W-1:0] ref_station;
    logic [BYTE_W-1:0]           ref_byte;
    logic                        byte_ones;
    logic                        byte_hit;

    always_comb begin
        sof_beat    = beat && sof;
        hdr_beat    = beat && !sof && collecting;
        cur_idx     = sof_beat ? '0 : idx_q;
        ref_station = sof_beat ? station_live : snap_station;
        ref_byte    = ref_station[int'(cur_idx)*BYTE_W +: BYTE_W];
        byte_ones   = &data;
        byte_hit    = (data == ref_byte);
        cur_bcast   = (sof_beat || ones_q) && byte_ones;
        cur_match   = (sof_beat || match_q) && byte_hit;
        cur_group   = sof_beat ? data[0] : group_q;
        last_beat   = hdr_beat && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q        <= '0;
            ones_q       <= 1'b0;
            match_q      <= 1'b0;
            group_q      <= 1'b0;
            snap_station <= '0;
            snap_mode    <= '0;
        end else if (sof_beat) begin
            idx_q        <= IDX_W'(1);
            ones_q       <= cur_bcast;
            match_q      <= cur_match;
            group_q      <= cur_group;
            snap_station <= station_live;
            snap_mode    <= mode_live;
        end else if (hdr_beat) begin
            idx_q        <= idx_q + IDX_W'(1);
            ones_q       <= cur_bcast;
            match_q      <= cur_match;
        end
    end

endmodule

// File: rtl/adf_ctrl.sv
module adf_ctrl
    import adf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      beat,
    input  logic      sof,
    input  logic      last_beat,
    input  logic      cur_bcast,
    input  logic      cur_group,
    input  logic      cur_match,
    input  adf_mode_t snap_mode,
    output logic      collecting,
    output logic      accept_o,
    output logic      drop_o
);

    adf_state_e state_q;
    adf_state_e state_n;
    logic       verdict;

    always_comb begin
        state_n = state_q;
        if (beat && sof) begin
            state_n = ST_HDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_HDR:  state_n = last_beat ? ST_TAIL : ST_HDR;
                ST_TAIL: state_n = ST_TAIL;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign collecting = (state_q == ST_HDR);

    // Fixed priority: promiscuous, broadcast, group, exact station match.
    always_comb begin
        if (snap_mode.promisc)  verdict = 1'b1;
        else if (cur_bcast)     verdict = snap_mode.bcast_en;
        else if (cur_group)     verdict = snap_mode.group_en;
        else                    verdict = cur_match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o <= 1'b0;
            drop_o   <= 1'b0;
        end else begin
            accept_o <= last_beat && verdict;
            drop_o   <= last_beat && !verdict;
        end
    end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import adf_pkg::*;
#(
    parameter int                          BYTE_W      = 8,
    parameter int                          ADDR_BYTES  = 6,
    parameter logic [ADDR_BYTES*BYTE_W-1:0] STATION_RST = 48'h525400123456,
    localparam int                         CFG_AW      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [BYTE_W-1:0] cfg_wr_data,
    output logic              accept,
    output logic              drop
);

    logic [ADDR_BYTES*BYTE_W-1:0] station_live;
    adf_mode_t                    mode_live;
    adf_mode_t                    snap_mode;
    logic                         collecting;
    logic                         last_beat;
    logic                         cur_bcast;
    logic                         cur_group;
    logic                         cur_match;

    adf_cfg_regs #(
        .BYTE_W      (BYTE_W),
        .ADDR_BYTES  (ADDR_BYTES),
        .STATION_RST (STATION_RST),
        .CFG_AW      (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .station_o (station_live),
        .mode_o    (mode_live)
    );

    adf_dest_track #(
        .BYTE_W     (BYTE_W),
        .ADDR_BYTES (ADDR_BYTES)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (in_valid),
        .sof          (in_sof),
        .data         (in_data),
        .collecting   (collecting),
        .station_live (station_live),
        .mode_live    (mode_live),
        .last_beat    (last_beat),
        .cur_bcast    (cur_bcast),
        .cur_group    (cur_group),
        .cur_match    (cur_match),
        .snap_mode    (snap_mode)
    );

    adf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (in_valid),
        .sof        (in_sof),
        .last_beat  (last_beat),
        .cur_bcast  (cur_bcast),
        .cur_group  (cur_group),
        .cur_match  (cur_match),
        .snap_mode  (snap_mode),
        .collecting (collecting),
        .accept_o   (accept),
        .drop_o     (drop)
    );

endmodule

// File: rtl/adf_chk.sv
module adf_chk
    import adf_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      in_valid,
    input logic      in_sof,
    input logic      accept,
    input logic      drop,
    input adf_mode_t snap_mode
);

    // R7
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && drop));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || drop) |=> !(accept || drop));

    // R7
    after_data_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || drop) |-> $past(in_valid && !in_sof));

    // R8
    no_verdict_after_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_sof) |-> !(accept || drop));

    // R1
    promisc_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !snap_mode.promisc);

endmodule

bind rx_dest_filter adf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .accept    (accept),
    .drop      (drop),
    .snap_mode (snap_mode)
);

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_addr = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       accept;
    logic       drop;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [47:0] m_stn;   // byte 0 (first on wire) in [47:40]
    logic [7:0]  m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sof      (in_sof),
        .in_data     (in_data),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .accept      (accept),
        .drop        (drop)
    );

    function automatic bit exp_keep(input logic [47:0] dest, input logic [47:0] stn,
                                    input logic [7:0] mode);
        if (mode[4])              return 1'b1;
        if (dest == 48'hFFFF_FFFF_FFFF) return mode[2];
        if (dest[40])             return mode[3];
        return dest == stn;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {accept,drop} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a < 3'd6) m_stn[(5-a)*8 +: 8] = d;
        else if (a == 3'd6) m_mode = d;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic idle_beat(input string req);
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        check(req, {accept, drop}, 2'b00);
    endtask

    // Drives a header plus tail; optional config write on header byte wr_at.
    task automatic send_frame(input logic [47:0] dest, input string req, input int gap_max,
                              input int tail, input int wr_at, input logic [2:0] wa,
                              input logic [7:0] wd);
        bit keep;
        keep = exp_keep(dest, m_stn, m_mode);
        for (int i = 0; i < 6; i++) begin
            if (i > 0 && gap_max > 0) begin
                int g = int'($urandom % (gap_max + 1));
                for (int k = 0; k < g; k++) idle_beat("R7");
            end
            in_valid = 1'b1; in_sof = (i == 0); in_data = dest[(5-i)*8 +: 8];
            if (i == wr_at) begin
                cfg_wr_en = 1'b1; cfg_wr_addr = wa; cfg_wr_data = wd;
            end
            @(negedge clk);
            if (i == wr_at) begin
                cfg_wr_en = 1'b0;
                model_write(wa, wd);
            end
            if (i < 5) check("R7", {accept, drop}, 2'b00);
            else       check(req, {accept, drop}, {keep, !keep});
        end
        for (int t = 0; t < tail; t++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_data = 8'($urandom);
            @(negedge clk);
            check("R7", {accept, drop}, 2'b00);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] d;
        void'($urandom(32'd20240611));
        m_stn  = 48'h525400123456;
        m_mode = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R5", {accept, drop}, 2'b00);

        // R8: beats without start-of-frame while idle are ignored
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_data = 8'($urandom);
            @(negedge clk);
            check("R8", {accept, drop}, 2'b00);
        end
        in_valid = 1'b0;

        // R5, R4: reset station is matched with mode clear
        send_frame(48'h525400123456, "R5", 0, 2, -1, 0, 0);
        send_frame(48'h525400123457, "R4", 1, 1, -1, 0, 0);
        send_frame(48'hD25400123456, "R4", 0, 0, -1, 0, 0);

        // R2: broadcast enable
        send_frame(48'hFFFF_FFFF_FFFF, "R2", 0, 0, -1, 0, 0);
        cfg_write(3'd6, 8'h04);
        send_frame(48'hFFFF_FFFF_FFFF, "R2", 2, 3, -1, 0, 0);

        // R6: broadcast does not fall into the group path
        cfg_write(3'd6, 8'h08);
        send_frame(48'hFFFF_FFFF_FFFF, "R6", 0, 0, -1, 0, 0);

        // R3: group frames with arbitrary trailing bytes
        send_frame(48'h01005E7F0001, "R3", 0, 0, -1, 0, 0);
        send_frame(48'hFFFF_FFFF_FFFE, "R3", 1, 0, -1, 0, 0);
        cfg_write(3'd6, 8'h00);
        send_frame(48'h01005E7F0001, "R3", 0, 0, -1, 0, 0);

        // R1: promiscuous
        cfg_write(3'd6, 8'h10);
        send_frame(48'h0A0B0C0D0E0F, "R1", 0, 0, -1, 0, 0);
        send_frame(48'hFFFF_FFFF_FFFF, "R1", 0, 0, -1, 0, 0);
        cfg_write(3'd6, 8'h00);

        // R9: new station through the write port
        for (int a = 0; a < 6; a++) cfg_write(3'(a), 8'(8'h20 + a));
        send_frame(48'h202122232425, "R9", 0, 0, -1, 0, 0);
        // write mid-header applies only to the next frame
        send_frame(48'h202122232425, "R9", 0, 1, 2, 3'd5, 8'h99);
        send_frame(48'h202122232425, "R9", 0, 0, -1, 0, 0);
        send_frame(48'h202122232499, "R9", 0, 0, 0, 3'd6, 8'h10);
        send_frame(48'h0A0B0C0D0E0F, "R9", 0, 0, -1, 0, 0);
        cfg_write(3'd6, 8'h00);

        // R8: restart cancels a partial header
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_data = 8'hFF;
            @(negedge clk);
            check("R8", {accept, drop}, 2'b00);
        end
        send_frame(48'h202122232499, "R8", 0, 0, -1, 0, 0);

        // Random frames mixed with random configuration
        for (int n = 0; n < 400; n++) begin
            logic [63:0] r;
            int cat;
            if (($urandom % 4) == 0) cfg_write(3'd6, 8'($urandom));
            if (($urandom % 8) == 0) cfg_write(3'($urandom % 6), 8'($urandom));
            r = {$urandom(), $urandom()};
            cat = int'($urandom % 5);
            case (cat)
                0: d = m_stn;
                1: d = m_stn ^ (48'h1 << ($urandom % 48));
                2: d = 48'hFFFF_FFFF_FFFF;
                3: d = r[47:0] | 48'h0100_0000_0000;
                default: d = r[47:0] & ~48'h0100_0000_0000;
            endcase
            send_frame(d, "R4", 2, int'($urandom % 4),
                       (($urandom % 6) == 0) ? int'($urandom % 6) : -1,
                       3'($urandom % 7), 8'($urandom));
            if (($urandom % 3) == 0) idle_beat("R7");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule